// File: doc/BRIEF.md
# Configurable Product-Term Cluster Allocator

This block is a programmable sum-of-products engine with sixteen outputs. Thirty-two logic inputs are offered to the array in both polarities. Sixty-four programmable AND terms are built from those literals. The terms are grouped four at a time into sixteen clusters. Each cluster can be handed to a single output, called a macrocell. A macrocell ORs together every cluster it owns. The outcome can then be XORed with a spare term and inverted. A cluster running in three-term mode gives its fourth term to its owner as that spare term.

Which clusters a macrocell may own is fixed by a sliding window, and neighbouring windows overlap. This lets one output gather up to eight clusters, which is thirty-two terms. Configuration arrives as a serial bit stream with a valid/ready handshake. A full shadow image is shifted in and then committed in one step. An image that breaks the window rules sets a sticky error flag. Once an image is committed, the path from `data_in` to `mc_out` is purely combinational.

Back-pressure rule: `cfg_ready` is high exactly while `cfg_load` is high. The block never stalls a stream while a load is open. A bit is taken only on a clock edge where `cfg_load`, `cfg_valid` and `cfg_ready` are all high. Outside a load no bit is taken.

Top module: `ptc_alloc`

## Requirements
- R1: The image is 4288 bits. Term p (0..63) sits at bits [p*65 +: 65]. Bit i (0..31) of that field includes the true form of `data_in[i]`. Bit 32+i includes its complement. Bit 64 enables the term. An enabled term with no literals gives 1, a disabled term gives 0, and a term that includes both forms of one input gives 0.
- R2: Cluster c owns terms 4c..4c+3, with 4c+3 as its fourth term. Its field sits at bit 4160+c*6. Bits [3:0] give the target macrocell, bit 4 is the assign flag, and bit 5 selects four-term mode. In four-term mode the cluster adds the OR of all four terms to its owner. In three-term mode it adds only terms 4c..4c+2.
- R3: A cluster whose assign flag is 0 contributes nothing to any output. A cluster can have only one owner, the macrocell named in its target field.
- R4: Macrocell m may own cluster c only if lo(m) <= c <= hi(m). For m = 0..15, lo is 0,0,0,0,0,1,2,3,5,6,7,8,8,9,10,11 and hi is 4,5,6,7,7,8,9,10,12,13,14,15,15,15,15,15. An image with only legal assignments leaves `config_error` unchanged.
- R5: An assigned cluster whose target window excludes it contributes nothing. Committing an image that holds any such cluster sets `config_error` on the commit edge. The flag stays at 1 until reset.
- R6: A macrocell ORs every cluster it legally owns, up to eight clusters (32 terms).
- R7: The spare input of macrocell m is the OR of the fourth terms of the three-term clusters it owns. It is 0 when there are none. It is XORed into the output only when the macrocell's xor-enable bit is 1. The macrocell field sits at bit 4256+m*2, with bit 0 the xor-enable and bit 1 the invert bit.
- R8: When the invert bit is 1, the macrocell output is inverted, including when the macrocell owns no cluster.
- R9: Serial load works as follows:
  - Bits shift in MSB first. The first accepted bit becomes image bit 4287.
  - `cfg_ready` equals `cfg_load`.
  - Bits offered with `cfg_valid` low are ignored.
  - The shadow image is committed on the first clock edge at which `cfg_load` is sampled low after being high.
  - `mc_out` is 0 while `cfg_load` is high and for the one cycle after it falls.
- R10: After reset the active image is all zero, `mc_out` is 0 and `config_error` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | High while a configuration image is streamed in |
| cfg_valid | input | 1 | Configuration bit valid |
| cfg_ready | output | 1 | Configuration bit accepted (equals cfg_load) |
| cfg_bit | input | 1 | Serial configuration data, MSB first |
| data_in | input | 32 | Logic inputs to the term array |
| mc_out | output | 16 | Macrocell outputs |
| config_error | output | 1 | Sticky flag for an image that broke the window rules |

## Verification
The bench aims at the edges of the window table:
- A cluster at the very edge of a macrocell's window (cluster 4 on macrocell 0, cluster 10 on macrocell 7) must be accepted.
- A cluster just outside a window must be dropped and must raise the sticky flag. A design with an off-by-one window would either raise a false error or let a forbidden cluster drive an output.

It also separates three term and spare cases that a careless design confuses:
- An empty enabled term must give 1 and a disabled term must give 0.
- A three-term cluster's spare must stay out of the OR.
- A spare must be ignored when xor-enable is 0.

Loads are streamed with bubbles and garbage on idle cycles, so a design that shifted without `cfg_valid` would commit a corrupted image. Outputs are checked in the gap cycle after `cfg_load` falls, where a design that commits too late would leak the old image.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  parameter int N_IN         = 32;
  parameter int TERMS_PER_CL = 4;
  parameter int N_CL         = 16;
  parameter int N_MC         = 16;
  parameter int MC_IDX_W     = 4;

  localparam int N_PT     = N_CL * TERMS_PER_CL;
  localparam int PT_W     = 2 * N_IN + 1;
  localparam int CL_W     = MC_IDX_W + 2;
  localparam int MC_W     = 2;
  localparam int CL_BASE  = N_PT * PT_W;
  localparam int MC_BASE  = CL_BASE + N_CL * CL_W;
  localparam int CFG_BITS = MC_BASE + N_MC * MC_W;

  // lowest cluster index macrocell m may own
  function automatic int win_lo(input int m);
    if (m <= 4)       return 0;
    else if (m <= 7)  return m - 4;
    else if (m <= 11) return m - 3;
    else if (m == 12) return 8;
    else              return m - 4;
  endfunction

  // highest cluster index macrocell m may own
  function automatic int win_hi(input int m);
    if (m <= 3)       return m + 4;
    else if (m == 4)  return 7;
    else if (m <= 7)  return m + 3;
    else if (m <= 10) return m + 4;
    else              return N_CL - 1;
  endfunction

  function automatic logic cluster_legal(input int c, input int m);
    return (m >= 0) && (m < N_MC) && (win_lo(m) <= c) && (c <= win_hi(m));
  endfunction
endpackage

// File: rtl/ptc_cfg_loader.sv
module ptc_cfg_loader
  import ptc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_load,
  input  logic                cfg_valid,
  input  logic                cfg_bit,
  output logic                cfg_ready,
  output logic [CFG_BITS-1:0] active_cfg,
  output logic                busy,
  output logic                config_error
);
  logic [CFG_BITS-1:0] shadow;
  logic                load_q;
  logic [N_CL-1:0]     bad;
  logic                commit;

  for (genvar c = 0; c < N_CL; c++) begin : g_rule
    logic [CL_W-1:0] fld;
    assign fld    = shadow[CL_BASE + c*CL_W +: CL_W];
    assign bad[c] = fld[MC_IDX_W] && !cluster_legal(c, int'(fld[MC_IDX_W-1:0]));
  end

  assign commit    = !cfg_load && load_q;
  assign cfg_ready = cfg_load;
  assign busy      = cfg_load || load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow       <= '0;
      active_cfg   <= '0;
      load_q       <= 1'b0;
      config_error <= 1'b0;
    end else begin
      load_q <= cfg_load;
      if (cfg_load && cfg_valid)
        shadow <= {shadow[CFG_BITS-2:0], cfg_bit};
      if (commit) begin
        active_cfg <= shadow;
        if (|bad)
          config_error <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptc_term_array.sv
module ptc_term_array
  import ptc_pkg::*;
(
  input  logic [N_IN-1:0]      data_in,
  input  logic [N_PT*PT_W-1:0] pt_cfg,
  output logic [N_PT-1:0]      pt_val
);
  for (genvar p = 0; p < N_PT; p++) begin : g_term
    logic [N_IN-1:0] use_true;
    logic [N_IN-1:0] use_comp;
    logic            enable;
    assign use_true  = pt_cfg[p*PT_W +: N_IN];
    assign use_comp  = pt_cfg[p*PT_W + N_IN +: N_IN];
    assign enable    = pt_cfg[p*PT_W + 2*N_IN];
    assign pt_val[p] = enable &
                       (&((~use_true | data_in) & (~use_comp | ~data_in)));
  end
endmodule

// File: rtl/ptc_cluster_router.sv
module ptc_cluster_router
  import ptc_pkg::*;
(
  input  logic [N_PT-1:0]      pt_val,
  input  logic [N_CL*CL_W-1:0] cl_cfg,
  output logic [N_MC-1:0]      mc_sum,
  output logic [N_MC-1:0]      mc_spare
);
  logic [N_CL-1:0]     cl_on;
  logic [N_CL-1:0]     cl_main;
  logic [N_CL-1:0]     cl_spare;
  logic [MC_IDX_W-1:0] cl_tgt [N_CL];

  for (genvar c = 0; c < N_CL; c++) begin : g_cl
    logic [CL_W-1:0]         fld;
    logic [TERMS_PER_CL-1:0] t;
    logic                    four;
    assign fld       = cl_cfg[c*CL_W +: CL_W];
    assign t         = pt_val[c*TERMS_PER_CL +: TERMS_PER_CL];
    assign four      = fld[MC_IDX_W+1];
    assign cl_tgt[c] = fld[MC_IDX_W-1:0];
    assign cl_on[c]  = fld[MC_IDX_W] && cluster_legal(c, int'(fld[MC_IDX_W-1:0]));
    assign cl_main[c]  = four ? (|t) : (|t[TERMS_PER_CL-2:0]);
    assign cl_spare[c] = !four && t[TERMS_PER_CL-1];
  end

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    always_comb begin
      mc_sum[m]   = 1'b0;
      mc_spare[m] = 1'b0;
      for (int c = 0; c < N_CL; c++) begin
        if (cl_on[c] && (cl_tgt[c] == MC_IDX_W'(m))) begin
          mc_sum[m]   = mc_sum[m] | cl_main[c];
          mc_spare[m] = mc_spare[m] | cl_spare[c];
        end
      end
    end
  end
endmodule

// File: rtl/ptc_macrocell.sv
module ptc_macrocell (
  input  logic sum_in,
  input  logic spare_in,
  input  logic xor_en,
  input  logic invert,
  input  logic blank,
  output logic mc_q
);
  assign mc_q = blank ? 1'b0 : (sum_in ^ (xor_en & spare_in) ^ invert);
endmodule

// File: rtl/ptc_alloc.sv
module ptc_alloc
  import ptc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic            cfg_valid,
  output logic            cfg_ready,
  input  logic            cfg_bit,
  input  logic [N_IN-1:0] data_in,
  output logic [N_MC-1:0] mc_out,
  output logic            config_error
);
  logic [CFG_BITS-1:0] active_cfg;
  logic                busy;
  logic [N_PT-1:0]     pt_val;
  logic [N_MC-1:0]     mc_sum;
  logic [N_MC-1:0]     mc_spare;

  ptc_cfg_loader u_loader (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_load     (cfg_load),
    .cfg_valid    (cfg_valid),
    .cfg_bit      (cfg_bit),
    .cfg_ready    (cfg_ready),
    .active_cfg   (active_cfg),
    .busy         (busy),
    .config_error (config_error)
  );

  ptc_term_array u_terms (
    .data_in (data_in),
    .pt_cfg  (active_cfg[CL_BASE-1:0]),
    .pt_val  (pt_val)
  );

  ptc_cluster_router u_router (
    .pt_val   (pt_val),
    .cl_cfg   (active_cfg[MC_BASE-1:CL_BASE]),
    .mc_sum   (mc_sum),
    .mc_spare (mc_spare)
  );

  for (genvar m = 0; m < N_MC; m++) begin : g_cell
    ptc_macrocell u_cell (
      .sum_in   (mc_sum[m]),
      .spare_in (mc_spare[m]),
      .xor_en   (active_cfg[MC_BASE + m*MC_W]),
      .invert   (active_cfg[MC_BASE + m*MC_W + 1]),
      .blank    (busy),
      .mc_q     (mc_out[m])
    );
  end
endmodule

// File: rtl/ptc_alloc_chk.sv
module ptc_alloc_chk
  import ptc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_load,
  input logic            cfg_valid,
  input logic            cfg_ready,
  input logic            cfg_bit,
  input logic [N_IN-1:0] data_in,
  input logic [N_MC-1:0] mc_out,
  input logic            config_error
);
  assert_blank_loading_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |-> (mc_out == '0));

  assert_blank_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load && $past(cfg_load)) |-> (mc_out == '0));

  assert_error_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |=> config_error);

  assert_error_on_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(config_error) |-> ($past(cfg_load, 2) && !$past(cfg_load)));

  assert_comb_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load && !$past(cfg_load) && !$past(cfg_load, 2) && $stable(data_in))
      |-> $stable(mc_out));

  logic unused_ok;
  assign unused_ok = cfg_valid ^ cfg_ready ^ cfg_bit;
endmodule

bind ptc_alloc ptc_alloc_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_load     (cfg_load),
  .cfg_valid    (cfg_valid),
  .cfg_ready    (cfg_ready),
  .cfg_bit      (cfg_bit),
  .data_in      (data_in),
  .mc_out       (mc_out),
  .config_error (config_error)
);

// File: tb/ptc_alloc_tb.sv
`timescale 1ns/1ps
module ptc_alloc_tb;
  localparam int TOT  = 4288;
  localparam int CLB  = 4160;
  localparam int MCB  = 4256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_bit = 1'b0;
  logic        cfg_ready;
  logic [31:0] data_in = '0;
  logic [15:0] mc_out;
  logic        config_error;

  always #2.5 clk = ~clk;

  ptc_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_bit(cfg_bit), .data_in(data_in),
    .mc_out(mc_out), .config_error(config_error)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R10";
  bit    done = 1'b0;

  int win_lo [16] = '{0,0,0,0,0,1,2,3,5,6,7,8,8,9,10,11};
  int win_hi [16] = '{4,5,6,7,7,8,9,10,12,13,14,15,15,15,15,15};

  logic [TOT-1:0] cfg_vec;
  logic [TOT-1:0] ref_shadow = '0;
  logic [TOT-1:0] ref_active = '0;
  logic           ref_lq = 1'b0;
  logic           ref_err = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_eval(input logic [TOT-1:0] cfg, input logic [31:0] din);
    logic [63:0] pt;
    logic [15:0] sum, spr, res;
    for (int p = 0; p < 64; p++) begin
      logic v;
      v = cfg[p*65 + 64];
      for (int i = 0; i < 32; i++) begin
        if (cfg[p*65 + i] && !din[i]) v = 1'b0;
        if (cfg[p*65 + 32 + i] && din[i]) v = 1'b0;
      end
      pt[p] = v;
    end
    sum = '0;
    spr = '0;
    for (int c = 0; c < 16; c++) begin
      int tgt;
      tgt = int'(cfg[CLB + c*6 +: 4]);
      if (cfg[CLB + c*6 + 4] && win_lo[tgt] <= c && c <= win_hi[tgt]) begin
        if (cfg[CLB + c*6 + 5])
          sum[tgt] = sum[tgt] | pt[4*c] | pt[4*c+1] | pt[4*c+2] | pt[4*c+3];
        else begin
          sum[tgt] = sum[tgt] | pt[4*c] | pt[4*c+1] | pt[4*c+2];
          spr[tgt] = spr[tgt] | pt[4*c+3];
        end
      end
    end
    for (int m = 0; m < 16; m++)
      res[m] = sum[m] ^ (cfg[MCB + m*2] & spr[m]) ^ cfg[MCB + m*2 + 1];
    return res;
  endfunction

  function automatic bit ref_bad(input logic [TOT-1:0] cfg);
    bit b;
    b = 1'b0;
    for (int c = 0; c < 16; c++) begin
      int tgt;
      tgt = int'(cfg[CLB + c*6 +: 4]);
      if (cfg[CLB + c*6 + 4] && !(win_lo[tgt] <= c && c <= win_hi[tgt])) b = 1'b1;
    end
    return b;
  endfunction

  // reference model state, advanced on the same edges as the design
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_shadow = '0;
      ref_active = '0;
      ref_lq     = 1'b0;
      ref_err    = 1'b0;
    end else begin
      if (!cfg_load && ref_lq) begin
        ref_active = ref_shadow;
        if (ref_bad(ref_shadow)) ref_err = 1'b1;
      end
      if (cfg_load && cfg_valid) ref_shadow = {ref_shadow[TOT-2:0], cfg_bit};
      ref_lq = cfg_load;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      logic [15:0] exp;
      exp = (cfg_load || ref_lq) ? 16'h0 : ref_eval(ref_active, data_in);
      chk(mc_out === exp, tag, "mc_out", {16'h0, mc_out}, {16'h0, exp});
      chk(config_error === ref_err, tag, "config_error", {31'h0, config_error}, {31'h0, ref_err});
      chk(cfg_ready === cfg_load, "R9", "cfg_ready", {31'h0, cfg_ready}, {31'h0, cfg_load});
    end
  end

  task automatic set_term(input int p, input bit en, input logic [31:0] tm, input logic [31:0] cm);
    cfg_vec[p*65 +: 32]      = tm;
    cfg_vec[p*65 + 32 +: 32] = cm;
    cfg_vec[p*65 + 64]       = en;
  endtask

  task automatic set_cl(input int c, input int tgt, input bit four);
    cfg_vec[CLB + c*6 +: 4] = 4'(tgt);
    cfg_vec[CLB + c*6 + 4]  = 1'b1;
    cfg_vec[CLB + c*6 + 5]  = four;
  endtask

  task automatic set_mc(input int m, input bit xen, input bit inv);
    cfg_vec[MCB + m*2]     = xen;
    cfg_vec[MCB + m*2 + 1] = inv;
  endtask

  task automatic send_cfg();
    int i;
    int n;
    i = TOT - 1;
    n = 0;
    tag = "R9";
    while (i >= 0) begin
      @(posedge clk); #1;
      cfg_load = 1'b1;
      data_in  = $urandom();
      n++;
      if (n % 9 == 0) begin
        cfg_valid = 1'b0;
        cfg_bit   = ~cfg_bit;
      end else begin
        cfg_valid = 1'b1;
        cfg_bit   = cfg_vec[i];
        i--;
      end
    end
    @(posedge clk); #1;
    cfg_load  = 1'b0;
    cfg_valid = 1'b0;
    cfg_bit   = $urandom();
    @(posedge clk); #1;
  endtask

  task automatic probe(input logic [31:0] v, input string req, input int m, input bit e);
    @(posedge clk); #1;
    data_in = v;
    @(negedge clk);
    chk(mc_out[m] === e, req, $sformatf("mc_out[%0d]", m), {31'h0, mc_out[m]}, {31'h0, e});
  endtask

  task automatic run_random(input string t, input int n);
    tag = t;
    repeat (n) begin
      @(posedge clk); #1;
      data_in = $urandom();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mc_out === 16'h0, "R10", "reset mc_out", {16'h0, mc_out}, 32'h0);
    chk(config_error === 1'b0, "R10", "reset config_error", {31'h0, config_error}, 32'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    run_random("R10", 5);

    // image 1: clusters 0..7 all onto macrocell 3 in four-term mode
    cfg_vec = '0;
    for (int p = 0; p < 32; p++) set_term(p, 1'b1, 32'h1 << p, 32'h0);
    set_term(9, 1'b0, 32'h1 << 9, 32'h0);
    set_term(10, 1'b1, 32'h1 << 11, 32'h1 << 10);
    set_term(11, 1'b0, 32'h0, 32'h0);
    for (int c = 0; c < 8; c++) set_cl(c, 3, 1'b1);
    send_cfg();
    probe(32'h0, "R6", 3, 1'b0);
    probe(32'h8000_0000, "R6", 3, 1'b1);
    probe(32'h0000_0008, "R2", 3, 1'b1);
    probe(32'h0000_0200, "R1", 3, 1'b0);
    probe(32'h0000_0800, "R1", 3, 1'b1);
    probe(32'h0000_0400, "R1", 3, 1'b0);
    probe(32'h0000_0C00, "R1", 3, 1'b0);
    probe(32'h0000_0001, "R3", 4, 1'b0);
    run_random("R6 R2 R3", 40);

    // image 2: three-term spare, polarity, empty term
    cfg_vec = '0;
    set_term(0, 1'b1, 32'h0, 32'h0);
    set_cl(0, 0, 1'b1);
    set_term(44, 1'b1, 32'h1, 32'h0);
    set_term(45, 1'b1, 32'h2, 32'h0);
    set_term(46, 1'b1, 32'h4, 32'h0);
    set_term(47, 1'b1, 32'h18, 32'h0);
    set_cl(11, 15, 1'b0);
    set_mc(15, 1'b1, 1'b0);
    set_term(48, 1'b1, 32'h0, 32'h20);
    set_cl(12, 12, 1'b1);
    set_mc(12, 1'b0, 1'b1);
    set_mc(14, 1'b1, 1'b1);
    set_term(52, 1'b1, 32'h40, 32'h0);
    set_term(55, 1'b1, 32'h0, 32'h0);
    set_cl(13, 13, 1'b0);
    send_cfg();
    probe(32'h0000_0018, "R7", 15, 1'b1);
    probe(32'h0000_0019, "R7", 15, 1'b0);
    probe(32'h0000_0000, "R7", 15, 1'b0);
    probe(32'h0000_0000, "R7", 13, 1'b0);
    probe(32'h0000_0000, "R8", 14, 1'b1);
    probe(32'h0000_0000, "R8", 12, 1'b0);
    probe(32'h0000_0020, "R8", 12, 1'b1);
    probe(32'hFFFF_FFFF, "R1", 0, 1'b1);
    run_random("R7 R8", 40);

    // image 3: cluster 0 aimed outside its window
    cfg_vec = '0;
    set_term(0, 1'b1, 32'h0, 32'h0);
    set_cl(0, 5, 1'b1);
    set_term(60, 1'b1, 32'h80, 32'h0);
    set_cl(15, 15, 1'b1);
    send_cfg();
    @(negedge clk);
    chk(config_error === 1'b1, "R5", "error after illegal image", {31'h0, config_error}, 32'h1);
    probe(32'h0000_0000, "R5", 5, 1'b0);
    probe(32'h0000_0080, "R3", 15, 1'b1);
    run_random("R5", 30);

    // image 4: legal clusters on window edges
    cfg_vec = '0;
    set_term(16, 1'b1, 32'h1, 32'h0);
    set_cl(4, 0, 1'b1);
    set_term(40, 1'b1, 32'h2, 32'h0);
    set_cl(10, 7, 1'b1);
    set_term(60, 1'b1, 32'h4, 32'h0);
    set_cl(15, 11, 1'b1);
    send_cfg();
    @(negedge clk);
    chk(config_error === 1'b1, "R5", "error sticky", {31'h0, config_error}, 32'h1);
    probe(32'h1, "R4", 0, 1'b1);
    probe(32'h2, "R4", 7, 1'b1);
    probe(32'h4, "R4", 11, 1'b1);

    // reset clears image and flag
    tag = "R10";
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(config_error === 1'b0, "R10", "error after reset", {31'h0, config_error}, 32'h0);
    chk(mc_out === 16'h0, "R10", "mc_out after reset", {16'h0, mc_out}, 32'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    run_random("R10", 5);

    send_cfg();
    @(negedge clk);
    chk(config_error === 1'b0, "R4", "no error on legal edges", {31'h0, config_error}, 32'h0);
    probe(32'h4, "R4", 11, 1'b1);
    run_random("R4", 30);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule